// File: doc/BRIEF.md
# Watchdog Control Register Front End

This block is the bus-facing control register of a watchdog timer. It holds three control bits: a sticky always-on bit, a window-mode select and a run enable. At power-on reset all three take their start-up values from non-volatile configuration inputs. Software reads and writes them over a simple peripheral bus that has an address, a write strobe, write data and combinational read data. The counter, the window comparator and the early-warning logic live elsewhere. They receive the effective run signal in their own clock domain, and they receive lock outputs that freeze the configuration and early-warning control registers.

A write to the enable bit reads back on the next cycle. The new value then crosses to the watchdog clock through a toggle request/acknowledge pair, and a busy flag stays high until the acknowledge returns. The bus side of the handshake is a two-state machine. In `XFER_IDLE`, an accepted enable write toggles the request and moves it to `XFER_WAIT`. In `XFER_WAIT`, it returns to `XFER_IDLE` once the synchronized acknowledge equals the request. The always-on bit is a second two-state machine. From `LOCK_OPEN` it moves to `LOCK_SEALED` when a bus write sets the bit. Only power-on reset leaves `LOCK_SEALED`, and it enters `LOCK_SEALED` directly when the configuration input asks for it. A system reset that is not a power-on reset reloads the other two bits and restarts the handshake, but it leaves the always-on bit alone.

Top module: `wdog_ctl_front`

## Requirements
- R1: The control register sits at byte address 0x00. Bit 7 is always-on, bit 2 is window mode and bit 1 is enable. Bits 6..3 and bit 0 read 0, any other address reads 0x00, and writes to any other address change nothing.
- R2: While `por_n` is low at a clock edge, the always-on, window and enable bits load `nv_aon`, `nv_win` and `nv_en`, and busy clears.
- R3: While `sys_rst_n` is low and `por_n` is high, window and enable reload from `nv_win` and `nv_en`, busy clears, and always-on keeps its value.
- R4: Writing 1 to bit 7 sets always-on. Writing 0 to it has no effect, and only power-on reset clears it.
- R5: While always-on is 1, every bus write to the control register is discarded. `cfg_wr_lock` and `ewc_wr_lock` are high exactly when always-on is 1.
- R6: Window mode takes bit 2 of a control write only when always-on is 0 and the enable bit held before that write is 0.
- R7: An enable write is accepted when always-on is 0 and busy is 0. The value reads back in the cycle after the write edge, and busy rises in that same cycle. Busy falls 2*SYNC_STAGES+2 edges after the write edge, which is 6 edges with the defaults and equal clocks.
- R8: The enable field of a control write that arrives while busy is 1 is ignored.
- R9: `wd_run` is the synchronized enable OR the always-on bit. With equal clocks, the synchronized enable takes the new value SYNC_STAGES+1 edges after the write edge, and always-on forces `wd_run` high in the cycle after it is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus clock |
| por_n | input | 1 | Power-on reset, synchronous, active low |
| sys_rst_n | input | 1 | System reset, synchronous, active low; spares always-on |
| nv_aon | input | 1 | Start-up value of always-on |
| nv_win | input | 1 | Start-up value of window mode |
| nv_en | input | 1 | Start-up value of enable |
| bus_addr | input | ADDR_W | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational on address |
| ctl_busy | output | 1 | Enable transfer in flight |
| cfg_wr_lock | output | 1 | Configuration register write lock |
| ewc_wr_lock | output | 1 | Early-warning control write lock |
| win_mode | output | 1 | Window mode select |
| wd_clk | input | 1 | Watchdog clock |
| wd_rst_n | input | 1 | Watchdog domain reset, synchronous, active low |
| wd_run | output | 1 | Effective enable in the watchdog domain |

## Verification
Register read-back, the lock outputs and the always-on effect on `wd_run` are all due in the cycle after the write edge. With both clocks tied together, the synchronized enable is due SYNC_STAGES+1 edges after the write and busy falls 2*SYNC_STAGES+2 edges after it. The bench model keeps a countdown for each of these two latencies. It drives every input at a falling edge and compares all outputs at the next falling edge, so each comparison lands exactly one rising edge after its stimulus.

// File: rtl/wdog_ctl_pkg.sv
package wdog_ctl_pkg;
    localparam int BIT_AON = 7;
    localparam int BIT_WIN = 2;
    localparam int BIT_EN  = 1;

    typedef enum logic {
        XFER_IDLE,
        XFER_WAIT
    } xfer_state_t;

    typedef enum logic {
        LOCK_OPEN,
        LOCK_SEALED
    } lock_state_t;
endpackage

// File: rtl/wdog_sync_chain.sv
module wdog_sync_chain #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d};
        end
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/wdog_lock_fsm.sv
module wdog_lock_fsm (
    input  logic clk,
    input  logic por_n,
    input  logic nv_aon,
    input  logic set_req,
    output logic sealed
);
    import wdog_ctl_pkg::*;

    lock_state_t state_q, state_d;

    // State register: only power-on reset reaches it
    always_ff @(posedge clk) begin
        if (!por_n) begin
            state_q <= nv_aon ? LOCK_SEALED : LOCK_OPEN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LOCK_OPEN:   if (set_req) state_d = LOCK_SEALED;
            LOCK_SEALED: state_d = LOCK_SEALED;
        endcase
    end

    always_comb begin
        sealed = (state_q == LOCK_SEALED);
    end
endmodule

// File: rtl/wdog_xfer_fsm.sv
module wdog_xfer_fsm #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic ack_tgl,
    output logic req_tgl,
    output logic busy
);
    import wdog_ctl_pkg::*;

    xfer_state_t state_q, state_d;
    logic        req_q;
    logic        ack_s;

    wdog_sync_chain #(.STAGES(STAGES)) u_ack_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ack_tgl),
        .q     (ack_s)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= XFER_IDLE;
            req_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == XFER_IDLE && start) begin
                req_q <= ~req_q;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            XFER_IDLE: if (start)          state_d = XFER_WAIT;
            XFER_WAIT: if (ack_s == req_q) state_d = XFER_IDLE;
        endcase
    end

    always_comb begin
        busy    = (state_q == XFER_WAIT);
        req_tgl = req_q;
    end
endmodule

// File: rtl/wdog_wd_side.sv
module wdog_wd_side #(
    parameter int STAGES = 2
) (
    input  logic wd_clk,
    input  logic wd_rst_n,
    input  logic nv_en,
    input  logic req_tgl,
    input  logic en_data,
    output logic en_wd,
    output logic ack_tgl
);
    logic req_s;
    logic ack_q;
    logic en_q;

    wdog_sync_chain #(.STAGES(STAGES)) u_req_sync (
        .clk   (wd_clk),
        .rst_n (wd_rst_n),
        .d     (req_tgl),
        .q     (req_s)
    );

    // en_data is held still by the bus side while a request is open
    always_ff @(posedge wd_clk) begin
        if (!wd_rst_n) begin
            ack_q <= 1'b0;
            en_q  <= nv_en;
        end else if (req_s != ack_q) begin
            ack_q <= req_s;
            en_q  <= en_data;
        end
    end

    assign en_wd   = en_q;
    assign ack_tgl = ack_q;
endmodule

// File: rtl/wdog_ctl_front.sv
module wdog_ctl_front #(
    parameter int                ADDR_W      = 8,
    parameter int                DATA_W      = 8,
    parameter int                SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0] CTL_OFFSET  = '0
) (
    input  logic              bus_clk,
    input  logic              por_n,
    input  logic              sys_rst_n,
    input  logic              nv_aon,
    input  logic              nv_win,
    input  logic              nv_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              ctl_busy,
    output logic              cfg_wr_lock,
    output logic              ewc_wr_lock,
    output logic              win_mode,
    input  logic              wd_clk,
    input  logic              wd_rst_n,
    output logic              wd_run
);
    import wdog_ctl_pkg::*;

    logic rst_all_n;
    logic ctl_hit, wr_open;
    logic set_aon, en_accept, win_accept;
    logic aon_q, win_q, en_q;
    logic busy;
    logic req_tgl, ack_tgl, en_wd;
    logic unused_wdata_bits;

    assign rst_all_n = por_n & sys_rst_n;

    // Write decode
    always_comb begin
        ctl_hit    = bus_wr && (bus_addr == CTL_OFFSET);
        wr_open    = ctl_hit && !aon_q;
        set_aon    = wr_open && bus_wdata[BIT_AON];
        en_accept  = wr_open && !busy;
        win_accept = wr_open && !en_q;
    end

    wdog_lock_fsm u_lock (
        .clk     (bus_clk),
        .por_n   (por_n),
        .nv_aon  (nv_aon),
        .set_req (set_aon),
        .sealed  (aon_q)
    );

    always_ff @(posedge bus_clk) begin
        if (!rst_all_n) begin
            win_q <= nv_win;
            en_q  <= nv_en;
        end else begin
            if (win_accept) win_q <= bus_wdata[BIT_WIN];
            if (en_accept)  en_q  <= bus_wdata[BIT_EN];
        end
    end

    wdog_xfer_fsm #(.STAGES(SYNC_STAGES)) u_xfer (
        .clk     (bus_clk),
        .rst_n   (rst_all_n),
        .start   (en_accept),
        .ack_tgl (ack_tgl),
        .req_tgl (req_tgl),
        .busy    (busy)
    );

    wdog_wd_side #(.STAGES(SYNC_STAGES)) u_wd (
        .wd_clk   (wd_clk),
        .wd_rst_n (wd_rst_n),
        .nv_en    (nv_en),
        .req_tgl  (req_tgl),
        .en_data  (en_q),
        .en_wd    (en_wd),
        .ack_tgl  (ack_tgl)
    );

    // Read mux
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == CTL_OFFSET) begin
            bus_rdata[BIT_AON] = aon_q;
            bus_rdata[BIT_WIN] = win_q;
            bus_rdata[BIT_EN]  = en_q;
        end
    end

    assign unused_wdata_bits = ^bus_wdata;
    assign ctl_busy    = busy;
    assign cfg_wr_lock = aon_q;
    assign ewc_wr_lock = aon_q;
    assign win_mode    = win_q;
    // always-on only ever rises, so it joins the watchdog domain directly
    assign wd_run      = en_wd | aon_q;
endmodule

// File: rtl/wdog_ctl_front_chk.sv
module wdog_ctl_front_chk #(
    parameter int                ADDR_W     = 8,
    parameter int                DATA_W     = 8,
    parameter logic [ADDR_W-1:0] CTL_OFFSET = '0
) (
    input logic              clk,
    input logic              por_n,
    input logic              sys_rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              aon,
    input logic              win,
    input logic              en,
    input logic              busy,
    input logic              wd_run
);
    logic hit;
    assign hit = bus_wr && (bus_addr == CTL_OFFSET);

    p_sticky_r4: assert property (@(posedge clk) disable iff (!por_n)
        aon |=> aon);

    p_discard_r5: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
        (hit && aon) |=> ($stable(win) && $stable(en)));

    p_win_guard_r6: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
        (hit && (en || aon)) |=> $stable(win));

    p_busy_set_r7: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
        (hit && !aon && !busy) |=> (busy && en == $past(bus_wdata[wdog_ctl_pkg::BIT_EN])));

    p_busy_hold_r8: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
        (hit && busy) |=> $stable(en));

    p_run_aon_r9: assert property (@(posedge clk) disable iff (!por_n)
        aon |-> wd_run);
endmodule

bind wdog_ctl_front wdog_ctl_front_chk #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .CTL_OFFSET (CTL_OFFSET)
) u_chk (
    .clk       (bus_clk),
    .por_n     (por_n),
    .sys_rst_n (sys_rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .aon       (aon_q),
    .win       (win_q),
    .en        (en_q),
    .busy      (busy),
    .wd_run    (wd_run)
);

// File: tb/wdog_ctl_front_tb_top.sv
module wdog_ctl_front_tb_top;
    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       sys_rst_n = 1'b1;
    logic       nv_aon = 1'b0, nv_win = 1'b0, nv_en = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       ctl_busy, cfg_wr_lock, ewc_wr_lock, win_mode, wd_run;
    logic       wd_rst_n;

    always #10 clk = ~clk;
    assign wd_rst_n = por_n & sys_rst_n;

    wdog_ctl_front dut_i (
        .bus_clk     (clk),
        .por_n       (por_n),
        .sys_rst_n   (sys_rst_n),
        .nv_aon      (nv_aon),
        .nv_win      (nv_win),
        .nv_en       (nv_en),
        .bus_addr    (bus_addr),
        .bus_wr      (bus_wr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .ctl_busy    (ctl_busy),
        .cfg_wr_lock (cfg_wr_lock),
        .ewc_wr_lock (ewc_wr_lock),
        .win_mode    (win_mode),
        .wd_clk      (clk),
        .wd_rst_n    (wd_rst_n),
        .wd_run      (wd_run)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    // Behavioural reference
    bit m_aon, m_win, m_en, m_wd, m_wd_val;
    int m_busy_left = 0;
    int m_wd_left = 0;
    localparam int BUSY_LAT = 6;
    localparam int WD_LAT   = 3;

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        if (bus_addr == 8'h00) begin
            chk("R4 always-on bit",  {7'd0, bus_rdata[7]}, {7'd0, m_aon});
            chk("R6 window bit",     {7'd0, bus_rdata[2]}, {7'd0, m_win});
            chk("R7 enable bit",     {7'd0, bus_rdata[1]}, {7'd0, m_en});
            chk("R1 reserved bits",  bus_rdata & 8'h79, 8'h00);
        end else begin
            chk("R1 other address", bus_rdata, 8'h00);
        end
        chk("R6 win_mode",      {7'd0, win_mode},    {7'd0, m_win});
        chk("R7 busy",          {7'd0, ctl_busy},    {7'd0, (m_busy_left > 0)});
        chk("R9 wd_run",        {7'd0, wd_run},      {7'd0, (m_wd | m_aon)});
        chk("R5 cfg lock",      {7'd0, cfg_wr_lock}, {7'd0, m_aon});
        chk("R5 ewc lock",      {7'd0, ewc_wr_lock}, {7'd0, m_aon});
    endtask

    task automatic cyc(input logic [7:0] a, input logic w, input logic [7:0] d,
                       input logic por, input logic sr);
        int pre_busy;
        bit old_en;
        bus_addr  = a;
        bus_wr    = w;
        bus_wdata = d;
        por_n     = por;
        sys_rst_n = sr;
        if (!por) begin
            m_aon = nv_aon; m_win = nv_win; m_en = nv_en; m_wd = nv_en;
            m_busy_left = 0; m_wd_left = 0;
        end else if (!sr) begin
            m_win = nv_win; m_en = nv_en; m_wd = nv_en;
            m_busy_left = 0; m_wd_left = 0;
        end else begin
            pre_busy = m_busy_left;
            old_en   = m_en;
            if (m_busy_left > 0) m_busy_left--;
            if (m_wd_left > 0) begin
                m_wd_left--;
                if (m_wd_left == 0) m_wd = m_wd_val;
            end
            if (w && a == 8'h00 && !m_aon) begin
                if (pre_busy == 0) begin
                    m_en = d[1]; m_wd_val = d[1];
                    m_busy_left = BUSY_LAT; m_wd_left = WD_LAT;
                end
                if (!old_en) m_win = d[2];
                if (d[7]) m_aon = 1'b1;
            end
        end
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(8'h00, 1'b0, 8'h00, 1'b1, 1'b1);
    endtask

    task automatic wr(input logic [7:0] d);
        cyc(8'h00, 1'b1, d, 1'b1, 1'b1);
    endtask

    task automatic por_seq(input bit a, input bit wn, input bit e);
        nv_aon = a; nv_win = wn; nv_en = e;
        for (int i = 0; i < 3; i++) cyc(8'h00, 1'b0, 8'h00, 1'b0, 1'b1);
        idle(1);
    endtask

    initial begin
        @(negedge clk);
        // R2: power-on load of all zeros
        por_seq(1'b0, 1'b0, 1'b0);
        chk("R2 post-POR rdata zero", bus_rdata, 8'h00);
        idle(2);

        // R7: enable write, immediate read-back, busy window
        wr(8'h02);
        chk("R7 enable reads back next cycle", bus_rdata, 8'h02);
        idle(2);
        // R8: enable write while busy is ignored
        wr(8'h00);
        chk("R8 enable kept while busy", bus_rdata, 8'h02);
        idle(6);

        // R6: window write while enabled is ignored
        wr(8'h06);
        idle(7);
        wr(8'h00);
        idle(7);
        // R6: window write while disabled is taken
        wr(8'h04);
        chk("R6 window set while disabled", bus_rdata, 8'h04);
        idle(7);
        wr(8'h7F);
        idle(7);

        // R1: writes and reads at another address
        cyc(8'h04, 1'b1, 8'h80, 1'b1, 1'b1);
        chk("R1 foreign write ignored", {7'd0, cfg_wr_lock}, 8'h00);
        cyc(8'hFF, 1'b0, 8'h00, 1'b1, 1'b1);
        idle(1);

        // R4/R5/R9: set always-on together with an enable-low write
        wr(8'h80);
        chk("R9 run forced by always-on", {7'd0, wd_run}, 8'h01);
        idle(7);
        wr(8'h00);
        wr(8'h02);
        chk("R4 writing zero has no effect", {7'd0, bus_rdata[7]}, 8'h01);
        idle(3);

        // R3: system reset keeps always-on, reloads the rest
        nv_win = 1'b1; nv_en = 1'b0;
        cyc(8'h00, 1'b0, 8'h00, 1'b1, 1'b0);
        cyc(8'h00, 1'b0, 8'h00, 1'b1, 1'b0);
        idle(1);
        chk("R3 sys reset keeps always-on", bus_rdata, 8'h84);

        // R2: power-on load with always-on from the configuration input
        por_seq(1'b1, 1'b0, 1'b1);
        chk("R2 POR loads always-on and enable", bus_rdata, 8'h82);
        wr(8'h00);
        idle(2);

        // R4: only POR clears always-on
        por_seq(1'b0, 1'b0, 1'b0);
        chk("R4 POR clears always-on", bus_rdata, 8'h00);

        // R3: system reset aborts a transfer in flight
        wr(8'h02);
        idle(1);
        cyc(8'h00, 1'b0, 8'h00, 1'b1, 1'b0);
        chk("R3 busy cleared by sys reset", {7'd0, ctl_busy}, 8'h00);
        idle(8);
        wr(8'h02);
        idle(7);
        chk("R9 run follows enable", {7'd0, wd_run}, 8'h01);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule